// File: doc/BRIEF.md
# SCSI Controller Command Gatekeeper

This block sits behind the command register of a SCSI protocol controller. Each byte the host writes there is checked against the controller's current bus-attachment mode before it may run. The checker looks at a three-bit group field inside the opcode. Accepted commands leave the block as a one-cycle execute strobe with the 7-bit code and a DMA flag. Rejected commands raise an illegal-command interrupt and go no further. The bus protocol, the DMA engine, the FIFOs and the execution of commands all sit downstream.

The block keeps its own record of the attachment mode. External events drive that mode: a selection that succeeds or fails, a hard reset, and an accepted message-accept command. The block also owns the interrupt-status and sequence-step registers. It updates them when the transfer phase of the running command completes. The interrupt request output is active while any interrupt-status bit is set. A host read of the interrupt register clears every bit.

Top module: `scsi_cmd_gate`

## Requirements
- R1: After reset, mode is 0 (disconnected), and the interrupt status, sequence step, command register, execute strobe and interrupt request are all 0.
- R2: A command whose bits [6:4] are 0 (miscellaneous group) is accepted in every mode. On the clock edge that registers the write, exec_stb pulses for one cycle with exec_code = byte[6:0] and exec_dma = byte[7].
- R3: In disconnected mode (0), only group 4 commands (bits [6:4] = 4) are accepted, along with miscellaneous ones. Any other group is rejected: interrupt bit 6 (0x40) is set and irq rises.
- R4: In initiator mode (1), only group 1 commands are accepted, along with miscellaneous ones. Any other group, group 4 included, is rejected with bit 0x40.
- R5: A rejected command produces no execute strobe. The written byte is still held in the command register.
- R6: A selection_ok pulse puts the block in initiator mode (1). A selection_fail pulse puts it in disconnected mode (0) and replaces the whole interrupt status with exactly 0x20.
- R7: An accepted message-accept command (code 0x12) returns the block to mode 0. It ORs 0x20 into the interrupt status, clears the sequence step to 0 and pulses flags_clr for one cycle.
- R8: xfer_done while the command register holds code 0x42 (select with attention) ORs 0x18 (bus service 0x10, function complete 0x08) into the interrupt status and loads sequence step 4.
- R9: xfer_done while the register holds code 0x43 (select with attention and stop) ORs in only 0x10 and loads sequence step 1.
- R10: xfer_done while the register holds code 0x10 (transfer information, with or without the DMA bit) clears the command register to 0 and ORs in 0x10.
- R11: Interrupt-status bits accumulate until an intr_rd pulse clears them all. irq is high exactly while the status is nonzero.
- R12: A hard_rst pulse forces mode 0 and clears the command, interrupt and sequence registers. A command written in the same cycle is ignored and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 8 | Command byte: [7] DMA flag, [6:4] group, [6:0] code |
| intr_rd | input | 1 | Host read of the interrupt register; clears it |
| sel_ok | input | 1 | Selection completed with a target answering |
| sel_fail | input | 1 | Selection timed out with no device answering |
| hard_rst | input | 1 | Synchronous hard reset event |
| xfer_done | input | 1 | Initial transfer phase of the current command completed |
| mode | output | 2 | Attachment mode: 0 disconnected, 1 initiator, 2 target |
| cmd_reg | output | 8 | Last written command byte |
| intr_status | output | 8 | Interrupt-status register |
| seq_step | output | 3 | Sequence-step register |
| irq | output | 1 | Interrupt request |
| exec_stb | output | 1 | One-cycle execute strobe for an accepted command |
| exec_code | output | 7 | Code of the accepted command |
| exec_dma | output | 1 | DMA flag of the accepted command |
| flags_clr | output | 1 | One-cycle request to clear the flags register |

## Verification
Several properties are checked on every cycle. A rejected write always sets the illegal bit. A strobe never appears without a write in the cycle before. A hard reset always lands in disconnected mode, a lone successful selection always lands in initiator mode, and a read with no new events always drops irq. Other behaviour can only be shown by the bench's ordered scenarios. These include the exact code and DMA flag carried by each strobe, the sequence-step values loaded per opcode, the clearing of the command register on transfer completion, the sticky build-up of status bits, and the overwrite done by a failed selection.

// File: rtl/scsi_cmd_gate_pkg.sv
package scsi_cmd_gate_pkg;
    typedef enum logic [1:0] {
        MODE_DISC = 2'd0,
        MODE_INIT = 2'd1,
        MODE_TGT  = 2'd2
    } gate_mode_e;

    localparam logic [2:0] GRP_MISC = 3'd0;
    localparam logic [2:0] GRP_INIT = 3'd1;
    localparam logic [2:0] GRP_TGT  = 3'd2;
    localparam logic [2:0] GRP_DISC = 3'd4;

    localparam logic [6:0] OP_XFER_INFO = 7'h10;
    localparam logic [6:0] OP_MSG_ACC   = 7'h12;
    localparam logic [6:0] OP_SEL_ATN   = 7'h42;
    localparam logic [6:0] OP_SEL_ATNS  = 7'h43;

    localparam logic [7:0] IRQ_FUNC_DONE = 8'h08;
    localparam logic [7:0] IRQ_BUS_SVC   = 8'h10;
    localparam logic [7:0] IRQ_DISCON    = 8'h20;
    localparam logic [7:0] IRQ_ILLEGAL   = 8'h40;

    localparam int SEQ_W = 3;
    localparam logic [SEQ_W-1:0] STEP_IDLE    = 3'd0;
    localparam logic [SEQ_W-1:0] STEP_MSG_OUT = 3'd1;
    localparam logic [SEQ_W-1:0] STEP_CMD     = 3'd4;
endpackage

// File: rtl/gate_group_check.sv
module gate_group_check
    import scsi_cmd_gate_pkg::*;
(
    input  logic [2:0] group,
    input  logic [1:0] mode,
    output logic       allowed
);
    always_comb begin
        allowed = 1'b0;
        if (group == GRP_MISC) begin
            allowed = 1'b1;
        end else begin
            case (mode)
                MODE_DISC: allowed = (group == GRP_DISC);
                MODE_INIT: allowed = (group == GRP_INIT);
                default:   allowed = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gate_mode_tracker.sv
module gate_mode_tracker
    import scsi_cmd_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hard_rst,
    input  logic       sel_ok,
    input  logic       sel_fail,
    input  logic       msg_acc_go,
    output logic [1:0] mode
);
    gate_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (hard_rst)        mode_d = MODE_DISC;
        else if (sel_fail)   mode_d = MODE_DISC;
        else if (msg_acc_go) mode_d = MODE_DISC;
        else if (sel_ok)     mode_d = MODE_INIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_DISC;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    p_hard_rst_disc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> (mode == MODE_DISC));
    p_sel_ok_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && !sel_fail && !hard_rst && !msg_acc_go) |=> (mode == MODE_INIT));
endmodule

// File: rtl/scsi_cmd_gate.sv
module scsi_cmd_gate
    import scsi_cmd_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_wdata,
    input  logic             intr_rd,
    input  logic             sel_ok,
    input  logic             sel_fail,
    input  logic             hard_rst,
    input  logic             xfer_done,
    output logic [1:0]       mode,
    output logic [7:0]       cmd_reg,
    output logic [7:0]       intr_status,
    output logic [SEQ_W-1:0] seq_step,
    output logic             irq,
    output logic             exec_stb,
    output logic [6:0]       exec_code,
    output logic             exec_dma,
    output logic             flags_clr
);
    typedef struct packed {
        logic [7:0]       cmd;
        logic [7:0]       intr;
        logic [SEQ_W-1:0] seq;
        logic             stb;
        logic [6:0]       code;
        logic             dma;
        logic             fclr;
    } gate_regs_t;

    gate_regs_t regs_d, regs_q;
    logic       cmd_ok;
    logic       msg_acc_go;

    gate_group_check u_check (
        .group   (cmd_wdata[6:4]),
        .mode    (mode),
        .allowed (cmd_ok)
    );

    assign msg_acc_go = cmd_wr && cmd_ok && !hard_rst && (cmd_wdata[6:0] == OP_MSG_ACC);

    gate_mode_tracker u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .hard_rst   (hard_rst),
        .sel_ok     (sel_ok),
        .sel_fail   (sel_fail),
        .msg_acc_go (msg_acc_go),
        .mode       (mode)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.stb  = 1'b0;
        regs_d.fclr = 1'b0;
        if (intr_rd) regs_d.intr = '0;
        if (hard_rst) begin
            regs_d = '0;
        end else begin
            if (xfer_done) begin
                case (regs_q.cmd[6:0])
                    OP_SEL_ATN: begin
                        regs_d.intr = regs_d.intr | IRQ_BUS_SVC | IRQ_FUNC_DONE;
                        regs_d.seq  = STEP_CMD;
                    end
                    OP_SEL_ATNS: begin
                        regs_d.intr = regs_d.intr | IRQ_BUS_SVC;
                        regs_d.seq  = STEP_MSG_OUT;
                    end
                    OP_XFER_INFO: begin
                        regs_d.cmd  = '0;
                        regs_d.intr = regs_d.intr | IRQ_BUS_SVC;
                    end
                    default: ;
                endcase
            end
            if (cmd_wr) begin
                regs_d.cmd = cmd_wdata;
                if (cmd_ok) begin
                    regs_d.stb  = 1'b1;
                    regs_d.code = cmd_wdata[6:0];
                    regs_d.dma  = cmd_wdata[7];
                    if (cmd_wdata[6:0] == OP_MSG_ACC) begin
                        regs_d.intr = regs_d.intr | IRQ_DISCON;
                        regs_d.seq  = STEP_IDLE;
                        regs_d.fclr = 1'b1;
                    end
                end else begin
                    regs_d.intr = regs_d.intr | IRQ_ILLEGAL;
                end
            end
            if (sel_fail) regs_d.intr = IRQ_DISCON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cmd_reg     = regs_q.cmd;
    assign intr_status = regs_q.intr;
    assign seq_step    = regs_q.seq;
    assign irq         = |regs_q.intr;
    assign exec_stb    = regs_q.stb;
    assign exec_code   = regs_q.code;
    assign exec_dma    = regs_q.dma;
    assign flags_clr   = regs_q.fclr;

    p_reject_flags_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_ok && !hard_rst && !sel_fail) |=> intr_status[6] && irq);
    p_strobe_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> $past(cmd_wr));
    p_reject_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_ok) |=> !exec_stb);
    p_read_drops_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_rd && !cmd_wr && !sel_fail && !xfer_done) |=> !irq);
endmodule

// File: tb/test_scsi_cmd_gate.sv
`timescale 1ns/1ps
module test_scsi_cmd_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       intr_rd = 1'b0;
    logic       sel_ok = 1'b0;
    logic       sel_fail = 1'b0;
    logic       hard_rst = 1'b0;
    logic       xfer_done = 1'b0;
    logic [1:0] mode;
    logic [7:0] cmd_reg;
    logic [7:0] intr_status;
    logic [2:0] seq_step;
    logic       irq;
    logic       exec_stb;
    logic [6:0] exec_code;
    logic       exec_dma;
    logic       flags_clr;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    scsi_cmd_gate i_scsi_cmd_gate (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .intr_rd(intr_rd), .sel_ok(sel_ok), .sel_fail(sel_fail),
        .hard_rst(hard_rst), .xfer_done(xfer_done), .mode(mode),
        .cmd_reg(cmd_reg), .intr_status(intr_status), .seq_step(seq_step),
        .irq(irq), .exec_stb(exec_stb), .exec_code(exec_code),
        .exec_dma(exec_dma), .flags_clr(flags_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected strobe for each exec_stb seen
    always @(negedge clk) begin
        if (rst_n && exec_stb) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R5: actual=%0h expected=none (unexpected strobe)",
                         {exec_dma, exec_code});
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if ({exec_dma, exec_code} !== e) begin
                    n_errors++;
                    $display("FAIL R2: actual=%0h expected=%0h", {exec_dma, exec_code}, e);
                end
            end
        end
    end

    // Driver: applies one write; the result is visible at the next negedge
    task automatic wr_cmd(input logic [7:0] v, input bit accept);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = v;
        if (accept) exp_q.push_back(v);
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: intr_rd = 1'b1;
            1: sel_ok = 1'b1;
            2: sel_fail = 1'b1;
            3: xfer_done = 1'b1;
            default: hard_rst = 1'b1;
        endcase
        @(negedge clk);
        intr_rd = 1'b0; sel_ok = 1'b0; sel_fail = 1'b0; xfer_done = 1'b0; hard_rst = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 intr", intr_status, 0);
        chk("R1 irq", irq, 0);
        chk("R1 seq", seq_step, 0);
        chk("R1 cmd", cmd_reg, 0);
        chk("R1 stb", exec_stb, 0);

        // R2 misc commands in disconnected mode, with and without DMA
        wr_cmd(8'h01, 1);
        chk("R2 no intr", intr_status, 0);
        wr_cmd(8'h80, 1);
        // R3 group 1 rejected while disconnected
        wr_cmd(8'h10, 0);
        chk("R3 illegal", intr_status, 8'h40);
        chk("R3 irq", irq, 1);
        chk("R5 cmd kept", cmd_reg, 8'h10);
        pulse(0);
        chk("R11 read clears", intr_status, 0);
        chk("R11 irq low", irq, 0);

        // R3 group 4 accepted, R8 transfer completion of select-with-attention
        wr_cmd(8'hC2, 1);
        pulse(3);
        chk("R8 intr", intr_status, 8'h18);
        chk("R8 seq", seq_step, 4);
        pulse(0);

        // R6 selection ok, R4 group 4 rejected in initiator mode
        pulse(1);
        chk("R6 mode init", mode, 1);
        wr_cmd(8'h43, 0);
        chk("R4 illegal", intr_status, 8'h40);
        chk("R5 cmd kept", cmd_reg, 8'h43);
        // R9 plus R11 stickiness
        pulse(3);
        chk("R9 intr sticky", intr_status, 8'h50);
        chk("R9 seq", seq_step, 1);
        pulse(0);

        // R4 group 1 accepted, R10 transfer information clears command
        wr_cmd(8'h90, 1);
        chk("R4 no illegal", intr_status, 0);
        pulse(3);
        chk("R10 cmd cleared", cmd_reg, 0);
        chk("R10 intr", intr_status, 8'h10);
        // R2 misc in initiator, R4 group 7 rejected
        wr_cmd(8'h03, 1);
        wr_cmd(8'h70, 0);
        chk("R4 group7", intr_status, 8'h50);
        pulse(0);

        // R7 message accept
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 8'h12; exp_q.push_back(8'h12);
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R7 flags_clr", flags_clr, 1);
        chk("R7 mode", mode, 0);
        chk("R7 intr", intr_status, 8'h20);
        chk("R7 seq", seq_step, 0);
        @(negedge clk);
        chk("R7 flags_clr pulse", flags_clr, 0);
        pulse(0);

        // R6 failed selection overwrites status
        pulse(1);
        wr_cmd(8'h40, 0);
        pulse(2);
        chk("R6 fail mode", mode, 0);
        chk("R6 fail intr", intr_status, 8'h20);
        pulse(0);

        // R12 hard reset with a coincident write
        pulse(1);
        wr_cmd(8'h10, 1);
        @(negedge clk);
        hard_rst = 1'b1; cmd_wr = 1'b1; cmd_wdata = 8'h02;
        @(negedge clk);
        hard_rst = 1'b0; cmd_wr = 1'b0;
        chk("R12 mode", mode, 0);
        chk("R12 cmd", cmd_reg, 0);
        chk("R12 intr", intr_status, 0);
        chk("R12 no stb", exec_stb, 0);

        repeat (2) @(negedge clk);
        chk("R2 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule